// File: doc/BRIEF.md
# PLL Lock Monitor Control Register

This block is one 8-bit register that sits on a simple CPU bus. It watches the lock indicator of a phase-locked loop and holds the PLL enable bit. The lock input is asynchronous. It passes through a synchronizer, and an edge detector then turns each gain of lock and each loss of lock into a sticky event flag. Software reads the register to see which event happened, and that read clears both flags. Each flag has its own interrupt enable. One level-sensitive interrupt line goes high while an enabled flag is set.

The block also guards the PLL enable bit. While the clock-mux selection shows that the PLL is driving the system clock, a write that would switch the PLL off is refused. A write that turns the PLL on is always accepted.

Top module: `pll_lockmon_reg`

## Requirements
- R1: After reset, every register bit is 0, `pll_en` is 0 and `lock_irq` is 0.
- R2: `bus_rdata` is the register image only while `bus_rd` is high and `bus_addr` equals `REG_ADDR` (default 0x5F). At all other times it is 0. Bits 7:6 of the image always read 0.
- R3: Image bit 5 is the live lock state after a two-flop synchronizer. A change on `pll_lock_in` shows there after the second rising clock edge.
- R4: Image bit 4 (lock-gained flag) is set by a rising edge of the synchronized lock. It stays set until a read of the register, which clears it on that read's clock edge.
- R5: Image bit 3 (lock-lost flag) is set by a falling edge of the synchronized lock. It stays set until a read of the register, which clears it.
- R6: A write to the register loads bit 2 (gained-event interrupt enable), bit 1 (lost-event interrupt enable) and bit 0 (PLL enable, driven on `pll_en`). Write-data bits 7:3 have no effect.
- R7: While `clk_sel` equals 2'b01, a write with data bit 0 = 0 leaves `pll_en` unchanged. Bits 2 and 1 are still written.
- R8: `lock_irq` is high exactly while (bit 4 and bit 2) or (bit 3 and bit 1) is true.
- R9: If a lock edge is detected in the same cycle as a register read, the read returns the old flag value and the flag is set afterwards, so the event is not lost.
- R10: A write or read strobe at any address other than `REG_ADDR` changes no register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; register image while addressed and read |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_wr | input | 1 | Write strobe, one clock per access |
| pll_lock_in | input | 1 | Asynchronous lock indicator from the PLL |
| clk_sel | input | MUX_W | Current clock-mux selection |
| pll_en | output | 1 | PLL enable |
| lock_irq | output | 1 | Lock event interrupt, level |

## Verification
The lock input is driven in three ways. Isolated single edges show that the two-cycle synchronizer delay and the rise/fall flag assignment are correct. Back-to-back toggles produce edges that arrive close together and show that both flags can be pending at once. Edges timed to land in the same cycle as a read show that clear-on-read never drops an event. The enable bit is written with every clock-mux selection, which separates the refused clear when the selection is 01 from ordinary writes. Random strobes at foreign addresses show that state is touched only by the register's own address.

// File: rtl/lockmon_pkg.sv
package lockmon_pkg;
   localparam int unsigned REG_W = 8;

   // Register image; field order is the bit order software decodes
   typedef struct packed {
      logic [1:0] rsvd;
      logic       locked;
      logic       ev_gain;
      logic       ev_lost;
      logic       ie_gain;
      logic       ie_lost;
      logic       en;
   } lm_image_t;

   localparam int unsigned BIT_IE_GAIN = 2;
   localparam int unsigned BIT_IE_LOST = 1;
   localparam int unsigned BIT_EN      = 0;
endpackage

// File: rtl/lockmon_sync.sv
module lockmon_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= async_in;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/lockmon_events.sv
module lockmon_events (
   input  logic clk,
   input  logic rst_n,
   input  logic lock_s,
   input  logic clr,
   output logic rise,
   output logic fall,
   output logic flag_gain,
   output logic flag_lost
);
   logic lock_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) lock_q <= 1'b0;
      else        lock_q <= lock_s;

   assign rise = lock_s & ~lock_q;
   assign fall = ~lock_s & lock_q;

   // a new edge wins over a clearing read in the same cycle
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         flag_gain <= 1'b0;
         flag_lost <= 1'b0;
      end else begin
         flag_gain <= (flag_gain & ~clr) | rise;
         flag_lost <= (flag_lost & ~clr) | fall;
      end
endmodule

// File: rtl/pll_lockmon_reg.sv
module pll_lockmon_reg
   import lockmon_pkg::*;
#(
   parameter int unsigned              ADDR_W      = 8,
   parameter logic [ADDR_W-1:0]        REG_ADDR    = 'h5F,
   parameter int unsigned              SYNC_STAGES = 2,
   parameter int unsigned              MUX_W       = 2,
   parameter logic [MUX_W-1:0]         PLL_SRC     = 'b01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic              pll_lock_in,
   input  logic [MUX_W-1:0]  clk_sel,
   output logic              pll_en,
   output logic              lock_irq
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (REG_W != 8) begin : g_bad_width
         $error("register image must be 8 bits");
      end
   endgenerate

   logic rd_hit, wr_hit, sel_pll;
   logic lock_s, rise, fall, flag_gain, flag_lost;
   logic ie_gain, ie_lost, en_q;
   lm_image_t image;
   logic unused_wbits;

   assign rd_hit  = bus_rd && (bus_addr == REG_ADDR);
   assign wr_hit  = bus_wr && (bus_addr == REG_ADDR);
   assign sel_pll = (clk_sel == PLL_SRC);
   assign unused_wbits = ^bus_wdata[7:3];

   lockmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(pll_lock_in), .sync_out(lock_s)
   );

   lockmon_events u_events (
      .clk(clk), .rst_n(rst_n), .lock_s(lock_s), .clr(rd_hit),
      .rise(rise), .fall(fall), .flag_gain(flag_gain), .flag_lost(flag_lost)
   );

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         ie_gain <= 1'b0;
         ie_lost <= 1'b0;
         en_q    <= 1'b0;
      end else if (wr_hit) begin
         ie_gain <= bus_wdata[BIT_IE_GAIN];
         ie_lost <= bus_wdata[BIT_IE_LOST];
         // switching off is refused while the PLL clocks the system
         en_q    <= bus_wdata[BIT_EN] | (en_q & sel_pll);
      end

   always_comb begin
      image         = '0;
      image.locked  = lock_s;
      image.ev_gain = flag_gain;
      image.ev_lost = flag_lost;
      image.ie_gain = ie_gain;
      image.ie_lost = ie_lost;
      image.en      = en_q;
   end

   assign bus_rdata = rd_hit ? image : 8'h00;
   assign pll_en    = en_q;
   assign lock_irq  = (flag_gain & ie_gain) | (flag_lost & ie_lost);
endmodule

// File: rtl/lockmon_chk.sv
module lockmon_chk #(
   parameter int unsigned       ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = 'h5F
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic              wdata_en,
   input logic [1:0]        clk_sel,
   input logic              pll_lock_in,
   input logic              lock_s,
   input logic              rise,
   input logic              fall,
   input logic              flag_gain,
   input logic              flag_lost,
   input logic              ie_gain,
   input logic              ie_lost,
   input logic              pll_en,
   input logic              lock_irq
);
   logic       rd_hit;
   logic [1:0] age;

   assign rd_hit = bus_rd && (bus_addr == REG_ADDR);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        age <= 2'd0;
      else if (age != 3) age <= age + 2'd1;

   // R7
   en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == REG_ADDR && !wdata_en && clk_sel == 2'b01 && pll_en) |=> pll_en);

   // R4
   gain_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_gain && !rd_hit) |=> flag_gain);

   // R5
   lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_lost && !rd_hit) |=> flag_lost);

   // R9
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && !rise && !fall) |=> (!flag_gain && !flag_lost));

   // R3
   sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2) |-> (lock_s == $past(pll_lock_in, 2)));

   // R8
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ie_gain && !ie_lost) |-> !lock_irq);
endmodule

bind pll_lockmon_reg lockmon_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_lockmon_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
   .wdata_en(bus_wdata[0]), .clk_sel(clk_sel), .pll_lock_in(pll_lock_in),
   .lock_s(lock_s), .rise(rise), .fall(fall), .flag_gain(flag_gain), .flag_lost(flag_lost),
   .ie_gain(ie_gain), .ie_lost(ie_lost), .pll_en(pll_en), .lock_irq(lock_irq)
);

// File: tb/test_pll_lockmon_reg.sv
module test_pll_lockmon_reg;
   localparam logic [7:0] RA = 8'h5F;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
   logic       bus_rd = 1'b0, bus_wr = 1'b0, pll_lock_in = 1'b0;
   logic [1:0] clk_sel = 2'b00;
   logic       pll_en, lock_irq;

   int total = 0, bad = 0;
   bit done = 0;

   // bench model of the register, from the requirements
   logic m_s1 = 0, m_s = 0, m_prev = 0, m_fg = 0, m_fl = 0, m_ig = 0, m_il = 0, m_en = 0;

   always #2 clk = ~clk;

   pll_lockmon_reg i_pll_lockmon_reg (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .pll_lock_in(pll_lock_in), .clk_sel(clk_sel), .pll_en(pll_en), .lock_irq(lock_irq)
   );

   function automatic logic [7:0] exp_image();
      return {2'b00, m_s, m_fg, m_fl, m_ig, m_il, m_en};
   endfunction

   function automatic logic exp_irq();
      return (m_fg & m_ig) | (m_fl & m_il);
   endfunction

   task automatic check(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
      end
   endtask

   // drive at the negedge, check 1ns later, advance the model at the posedge
   task automatic step(input string tag, input logic lk, input logic [1:0] sel,
                       input logic rd, input logic wr, input logic [7:0] addr, input logic [7:0] wd);
      logic rise, fall, rhit, whit;
      pll_lock_in = lk; clk_sel = sel; bus_rd = rd; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
      #1;
      check(tag, "rdata", bus_rdata, (rd && addr == RA) ? exp_image() : 8'h00);
      check("R8", "irq", {7'b0, lock_irq}, {7'b0, exp_irq()});
      check("R6", "pll_en", {7'b0, pll_en}, {7'b0, m_en});
      @(posedge clk);
      rise = m_s & ~m_prev;
      fall = ~m_s & m_prev;
      rhit = rd && addr == RA;
      whit = wr && addr == RA;
      m_fg = (m_fg & ~rhit) | rise;
      m_fl = (m_fl & ~rhit) | fall;
      if (whit) begin
         m_ig = wd[2];
         m_il = wd[1];
         m_en = wd[0] | (m_en & (sel == 2'b01));
      end
      m_prev = m_s; m_s = m_s1; m_s1 = lk;
      @(negedge clk);
   endtask

   task automatic idle(input string tag, input int n);
      for (int i = 0; i < n; i++) step(tag, pll_lock_in, clk_sel, 0, 0, RA, 8'h00);
   endtask

   initial begin
      #(4 * 150000);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h1D5EED));
      @(negedge clk); @(negedge clk);
      // R1: state right after reset
      #1;
      check("R1", "irq_in_reset", {7'b0, lock_irq}, 8'h00);
      check("R1", "en_in_reset", {7'b0, pll_en}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      step("R1", 0, 2'b00, 1, 0, RA, 8'h00);
      // R2: unaddressed read returns 0
      step("R2", 0, 2'b00, 1, 0, 8'h5E, 8'h00);
      // R6: upper write bits have no effect
      step("R6", 0, 2'b00, 0, 1, RA, 8'hFF);
      step("R6", 0, 2'b00, 1, 0, RA, 8'h00);
      // R10: foreign-address write is ignored
      step("R10", 0, 2'b00, 0, 1, 8'h60, 8'h00);
      step("R10", 0, 2'b00, 1, 0, RA, 8'h00);
      // R3 / R4: gain lock, live bit after two edges, flag after three
      step("R3", 1, 2'b00, 0, 0, RA, 8'h00);
      step("R3", 1, 2'b00, 1, 0, RA, 8'h00);
      step("R3", 1, 2'b00, 1, 0, RA, 8'h00);
      idle("R4", 2);
      step("R4", 1, 2'b00, 1, 0, RA, 8'h00);
      step("R4", 1, 2'b00, 1, 0, RA, 8'h00);
      // R5: loss of lock raises the irq with the lost enable set
      step("R5", 0, 2'b00, 0, 0, RA, 8'h00);
      idle("R5", 3);
      step("R5", 0, 2'b00, 1, 0, RA, 8'h00);
      // R9: falling edge detected in the cycle of a read
      step("R9", 1, 2'b00, 0, 0, RA, 8'h00);
      idle("R9", 3);
      step("R9", 1, 2'b00, 1, 0, RA, 8'h00);
      step("R9", 0, 2'b00, 0, 0, RA, 8'h00);
      step("R9", 0, 2'b00, 0, 0, RA, 8'h00);
      step("R9", 0, 2'b00, 1, 0, RA, 8'h00);
      step("R9", 0, 2'b00, 1, 0, RA, 8'h00);
      // R7: clearing the enable is refused only while the selection is 01
      step("R7", 0, 2'b01, 0, 1, RA, 8'h00);
      step("R7", 0, 2'b01, 1, 0, RA, 8'h00);
      step("R7", 0, 2'b10, 0, 1, RA, 8'h04);
      step("R7", 0, 2'b10, 1, 0, RA, 8'h00);
      step("R7", 0, 2'b01, 0, 1, RA, 8'h01);
      step("R7", 0, 2'b01, 1, 0, RA, 8'h00);
      // random traffic, including fast lock toggles and foreign addresses
      for (int i = 0; i < 4000; i++) begin
         logic lk;
         logic [7:0] a;
         lk = (($urandom % 6) == 0) ? ~pll_lock_in : pll_lock_in;
         a  = (($urandom % 8) == 0) ? 8'($urandom) : RA;
         step("R4 R5 R10 rnd", lk, 2'($urandom), ($urandom % 3) == 0,
              ($urandom % 4) == 0, a, 8'($urandom));
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule